// File: doc/BRIEF.md
# Power Stage Reset Sequencer

This block sits on the controller side of a switching audio power stage. It drives the stage's active-low reset line. It keeps that line low while the stage's bootstrap capacitors charge after the gate supply comes up. It releases the line only when the modulator reports that it has initialised and the PWM stream it sends has been measured and found to switch at a legal rate.

The stream is checked against the block's own reference clock. The sequencer counts reference cycles between successive rising edges of the PWM signal. A run of consecutive periods that all fall inside a programmable window qualifies the stream. A stream that stops toggling, whether it is stuck high or stuck low, disqualifies it at once.

Shutdown and mute requests pull the reset low on the next clock, before the modulator stops switching. A permission flag then tells the modulator when the reset has been held low long enough that stopping PWM is safe.

Top module: `pstage_rst_seq`

## Requirements
- R1: After `supply_good` rises, `stage_rst_n` stays low for at least PRECHARGE_CYC reference cycles (default 50000, 1 ms at 50 MHz). A drop of `supply_good` restarts this wait from zero.
- R2: `stage_rst_n` is high only while `mod_ready` was high in the previous cycle.
- R3: The stream qualifies as valid after QUAL_PERIODS consecutive rising-edge-to-rising-edge periods (default 8), each between PER_MIN_CYC and PER_MAX_CYC reference cycles inclusive (defaults 125 and 143). At a 50 MHz clock this is the 350 to 400 kHz band. One period outside the window, too short or too long, drops qualification, and reset goes low until a fresh run of good periods has been seen.
- R4: If no rising PWM edge is seen for more than TIMEOUT_CYC cycles (default 200, 4 µs), the stream is invalid and `stage_rst_n` goes low. A PWM held constantly high or constantly low is never accepted.
- R5: While `shutdown_req` is high, `stage_rst_n` is low from the next cycle on, so reset falls while PWM is still switching.
- R6: While `mute_req` is high, `stage_rst_n` is low from the next cycle on. When mute clears and every other condition still holds, reset is released again without a new precharge wait.
- R7: `pwm_stop_ok` is high only while `stage_rst_n` is low and has been low for at least 2×PER_MAX_CYC consecutive cycles. It is low whenever `stage_rst_n` is high.
- R8: During and right after the block reset `rst_n`, `stage_rst_n` and `pwm_stop_ok` are both low.
- R9: If `supply_good` is low, `stage_rst_n` is low from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| supply_good | input | 1 | Gate drive supply is within range |
| mod_ready | input | 1 | Modulator initialised and streaming |
| pwm_in | input | 1 | Copy of the PWM stream sent to the stage (asynchronous) |
| mute_req | input | 1 | Request to stop output switching |
| shutdown_req | input | 1 | Request to power the stage down |
| stage_rst_n | output | 1 | Active-low reset to the power stage |
| pwm_stop_ok | output | 1 | Modulator may now stop PWM |

## Verification
The assertions assume that `pwm_in` reaches the block as a clean level without glitches shorter than a clock. They also assume that the control inputs hold a known value from time zero. The stage-release check relies on the raw PWM edge gap, and so it allows a few cycles of synchroniser latency. The stimulus drives every control input from the start of time and changes it only between clock edges. It generates PWM as a square wave whose period is a whole number of clock periods, so each measured period lands within one cycle of its nominal value. The legal, fast and slow test periods sit well clear of the window limits.

// File: rtl/pstage_rst_seq.sv
module pstage_rst_seq #(
  parameter int PRECHARGE_CYC = 50000,
  parameter int PER_MIN_CYC   = 125,
  parameter int PER_MAX_CYC   = 143,
  parameter int QUAL_PERIODS  = 8,
  parameter int TIMEOUT_CYC   = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_good,
  input  logic mod_ready,
  input  logic pwm_in,
  input  logic mute_req,
  input  logic shutdown_req,
  output logic stage_rst_n,
  output logic pwm_stop_ok
);
  localparam int STOP_WAIT = 2 * PER_MAX_CYC;
  localparam int PW = $clog2(TIMEOUT_CYC + 2);
  localparam int CW = $clog2(PRECHARGE_CYC + 1);
  localparam int QW = $clog2(QUAL_PERIODS + 1);
  localparam int SW = $clog2(STOP_WAIT + 1);
  localparam logic [PW-1:0] PER_SAT = PW'(TIMEOUT_CYC + 1);
  localparam logic [PW-1:0] PER_LO  = PW'(PER_MIN_CYC);
  localparam logic [PW-1:0] PER_HI  = PW'(PER_MAX_CYC);
  localparam logic [CW-1:0] PRE_END = CW'(PRECHARGE_CYC);
  localparam logic [QW-1:0] QUAL_N  = QW'(QUAL_PERIODS);
  localparam logic [SW-1:0] STOP_N  = SW'(STOP_WAIT);

  logic [2:0]    pwm_sync;
  logic [PW-1:0] per_cnt;
  logic          have_edge;
  logic [QW-1:0] qual_cnt;
  logic [CW-1:0] pre_cnt;
  logic [SW-1:0] low_cnt;

  wire pwm_rise  = pwm_sync[1] & ~pwm_sync[2];
  wire stale     = per_cnt == PER_SAT;
  wire in_win    = (per_cnt >= PER_LO) && (per_cnt <= PER_HI);
  wire stream_ok = qual_cnt == QUAL_N;
  wire charged   = pre_cnt == PRE_END;
  wire release_ok = supply_good & charged & mod_ready & stream_ok &
                    ~mute_req & ~shutdown_req;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pwm_sync <= '0;
    else        pwm_sync <= {pwm_sync[1:0], pwm_in};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        per_cnt <= PER_SAT;
    else if (pwm_rise) per_cnt <= PW'(1);
    else if (!stale)   per_cnt <= per_cnt + PW'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        have_edge <= 1'b0;
    else if (pwm_rise) have_edge <= 1'b1;
    else if (stale)    have_edge <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) qual_cnt <= '0;
    else if (stale) qual_cnt <= '0;
    else if (pwm_rise) begin
      if (!have_edge || !in_win) qual_cnt <= '0;
      else if (!stream_ok)       qual_cnt <= qual_cnt + QW'(1);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)            pre_cnt <= '0;
    else if (!supply_good) pre_cnt <= '0;
    else if (!charged)     pre_cnt <= pre_cnt + CW'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) stage_rst_n <= 1'b0;
    else        stage_rst_n <= release_ok;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)              low_cnt <= '0;
    else if (stage_rst_n)    low_cnt <= '0;
    else if (low_cnt != STOP_N) low_cnt <= low_cnt + SW'(1);

  assign pwm_stop_ok = ~stage_rst_n & (low_cnt == STOP_N);
endmodule

// File: rtl/pstage_rst_seq_chk.sv
module pstage_rst_seq_chk #(
  parameter int PRECHARGE_CYC = 50000,
  parameter int PER_MAX_CYC   = 143,
  parameter int TIMEOUT_CYC   = 200
) (
  input logic clk,
  input logic rst_n,
  input logic supply_good,
  input logic mod_ready,
  input logic pwm_in,
  input logic mute_req,
  input logic shutdown_req,
  input logic stage_rst_n,
  input logic pwm_stop_ok
);
  localparam int STOP_WAIT = 2 * PER_MAX_CYC;
  localparam int GAP_LIM = TIMEOUT_CYC + 8;
  localparam int CW = $clog2(PRECHARGE_CYC + 1);
  localparam int GW = $clog2(GAP_LIM + 1);
  localparam int SW = $clog2(STOP_WAIT + 1);
  localparam logic [CW-1:0] SUP_N = CW'(PRECHARGE_CYC);
  localparam logic [GW-1:0] GAP_N = GW'(GAP_LIM);
  localparam logic [SW-1:0] LOW_N = SW'(STOP_WAIT);

  logic [CW-1:0] sup_cnt;
  logic [GW-1:0] gap_cnt;
  logic [SW-1:0] low_seen;
  logic          pwm_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sup_cnt <= '0;
    else if (!supply_good) sup_cnt <= '0;
    else if (sup_cnt != SUP_N) sup_cnt <= sup_cnt + CW'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pwm_q <= 1'b0;
      gap_cnt <= GAP_N;
    end else begin
      pwm_q <= pwm_in;
      if (pwm_in && !pwm_q)    gap_cnt <= '0;
      else if (gap_cnt != GAP_N) gap_cnt <= gap_cnt + GW'(1);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) low_seen <= '0;
    else if (stage_rst_n) low_seen <= '0;
    else if (low_seen != LOW_N) low_seen <= low_seen + SW'(1);

  p_precharge_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stage_rst_n) |-> $past(sup_cnt) == SUP_N);
  p_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stage_rst_n |-> $past(mod_ready));
  p_stale_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stage_rst_n |-> gap_cnt != GAP_N);
  p_shutdown_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(shutdown_req) |-> !stage_rst_n);
  p_mute_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mute_req) |-> !stage_rst_n);
  p_stop_ok_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_stop_ok |-> (!stage_rst_n && low_seen == LOW_N));
  p_supply_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!supply_good) |-> !stage_rst_n);
endmodule

bind pstage_rst_seq pstage_rst_seq_chk #(
  .PRECHARGE_CYC(PRECHARGE_CYC),
  .PER_MAX_CYC(PER_MAX_CYC),
  .TIMEOUT_CYC(TIMEOUT_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .supply_good(supply_good), .mod_ready(mod_ready),
  .pwm_in(pwm_in), .mute_req(mute_req), .shutdown_req(shutdown_req),
  .stage_rst_n(stage_rst_n), .pwm_stop_ok(pwm_stop_ok)
);

// File: tb/pstage_rst_seq_tb.sv
`timescale 1ns/1ps
module pstage_rst_seq_tb;
  localparam int PRE = 3000;
  localparam int STOP_WAIT = 2 * 143;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_good = 1'b0;
  logic mod_ready = 1'b0;
  logic pwm = 1'b0;
  logic mute_req = 1'b0;
  logic shutdown_req = 1'b0;
  logic stage_rst_n, pwm_stop_ok;

  int errors = 0;
  int checks = 0;
  int per_ns = 2600;
  int pmode = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pstage_rst_seq #(.PRECHARGE_CYC(PRE)) u_dut (
    .clk(clk), .rst_n(rst_n), .supply_good(supply_good), .mod_ready(mod_ready),
    .pwm_in(pwm), .mute_req(mute_req), .shutdown_req(shutdown_req),
    .stage_rst_n(stage_rst_n), .pwm_stop_ok(pwm_stop_ok)
  );

  initial forever begin
    if (pmode == 0) begin
      pwm = 1'b1; #(per_ns / 2);
      pwm = 1'b0; #(per_ns / 2);
    end else begin
      pwm = (pmode == 1); #20;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #5;
  endtask

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic t_reset;
    cyc(5);
    check("R8", "rst during reset", stage_rst_n, 1'b0);
    check("R8", "stop_ok during reset", pwm_stop_ok, 1'b0);
    rst_n = 1'b1;
    cyc(3);
    check("R8", "rst after reset", stage_rst_n, 1'b0);
    check("R8", "stop_ok after reset", pwm_stop_ok, 1'b0);
  endtask

  task automatic t_powerup;
    mod_ready = 1'b1;
    cyc(2000);
    supply_good = 1'b1;
    cyc(PRE - 10);
    check("R1", "rst before precharge end", stage_rst_n, 1'b0);
    cyc(20);
    check("R1", "rst after precharge with valid stream", stage_rst_n, 1'b1);
    check("R7", "stop_ok while released", pwm_stop_ok, 1'b0);
  endtask

  task automatic t_mute;
    mute_req = 1'b1;
    cyc(2);
    check("R6", "rst under mute", stage_rst_n, 1'b0);
    cyc(100);
    check("R7", "stop_ok too early", pwm_stop_ok, 1'b0);
    cyc(STOP_WAIT);
    check("R7", "stop_ok after wait", pwm_stop_ok, 1'b1);
    mute_req = 1'b0;
    cyc(3);
    check("R6", "rst after unmute", stage_rst_n, 1'b1);
    check("R7", "stop_ok cleared", pwm_stop_ok, 1'b0);
  endtask

  task automatic t_not_ready;
    mod_ready = 1'b0;
    cyc(2);
    check("R2", "rst with modulator not ready", stage_rst_n, 1'b0);
    cyc(50);
    check("R2", "rst stays low", stage_rst_n, 1'b0);
    mod_ready = 1'b1;
    cyc(3);
    check("R2", "rst with modulator ready", stage_rst_n, 1'b1);
  endtask

  task automatic t_stuck(input int mode, input string what);
    pmode = mode;
    cyc(400);
    check("R4", {what, " detected"}, stage_rst_n, 1'b0);
    cyc(1000);
    check("R4", {what, " never accepted"}, stage_rst_n, 1'b0);
    pmode = 0;
    cyc(500);
    check("R3", "not released before full qualification", stage_rst_n, 1'b0);
    cyc(1000);
    check("R3", "released after requalification", stage_rst_n, 1'b1);
  endtask

  task automatic t_badfreq(input int p, input string what);
    per_ns = p;
    cyc(600);
    check("R3", {what, " period rejected"}, stage_rst_n, 1'b0);
    cyc(1200);
    check("R3", {what, " still rejected"}, stage_rst_n, 1'b0);
    per_ns = 2600;
    cyc(500);
    check("R3", "partial requalification", stage_rst_n, 1'b0);
    cyc(1000);
    check("R3", "requalified", stage_rst_n, 1'b1);
  endtask

  task automatic t_supply;
    supply_good = 1'b0;
    cyc(2);
    check("R9", "rst on supply loss", stage_rst_n, 1'b0);
    cyc(20);
    supply_good = 1'b1;
    cyc(PRE - 10);
    check("R1", "precharge restarted", stage_rst_n, 1'b0);
    cyc(20);
    check("R1", "released after second precharge", stage_rst_n, 1'b1);
  endtask

  task automatic t_shutdown;
    shutdown_req = 1'b1;
    cyc(2);
    check("R5", "rst on shutdown with PWM running", stage_rst_n, 1'b0);
    check("R7", "stop_ok right after shutdown", pwm_stop_ok, 1'b0);
    cyc(STOP_WAIT - 20);
    check("R7", "stop_ok before two periods", pwm_stop_ok, 1'b0);
    cyc(40);
    check("R7", "stop_ok after two periods", pwm_stop_ok, 1'b1);
    pmode = 2;
    cyc(500);
    check("R5", "rst stays low after PWM stops", stage_rst_n, 1'b0);
    check("R7", "stop_ok holds", pwm_stop_ok, 1'b1);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_powerup();
    t_mute();
    t_not_ready();
    t_stuck(1, "stuck high");
    t_stuck(2, "stuck low");
    t_badfreq(2200, "fast");
    t_badfreq(3200, "slow");
    t_supply();
    t_shutdown();
    finish_run();
  end
endmodule